// File: doc/BRIEF.md
# System-Bus Slave Address Decoder

This block is the slave-side front end of one memory controller on an asynchronous, interlocked system bus. It watches an 18-bit address, a master sync strobe and a two-bit cycle type. It claims a cycle only when the upper address bits fall inside the range set on its configuration inputs. A claimed address is turned into the internal memory address register value, and one of four array modules is selected from it. The block then raises a request to the array side and waits for completion.

When the array side signals completion, the block raises slave sync. On a write this happens after the write data and byte enables have been captured for storage. On a read the read word is also placed on the bus data lines. Slave sync and the read drivers stay active until the master removes its sync. The bidirectional data lines are modelled as a separate input, a separate output and an output enable.

Top module: `sysbus_slave_front`

## Requirements
- R1: A cycle is claimed only when master sync is high in the idle state and every address bit 17..13 whose `cfg_mask` bit is 1 equals the matching `cfg_base` bit (`cfg_base[4]` pairs with address bit 17). A bit whose mask is 0 is ignored. An unclaimed cycle produces neither `mem_req` nor slave sync.
- R2: On a claim, the memory address register takes address bits 12..2 into its bits 11..1, and address bits 14..13 into its bits 14..13.
- R3: With `cfg_route`=0, address bit 15 goes to register bit 12 and address bit 1 goes to register bit 0. With `cfg_route`=1 these two routes are swapped.
- R4: `mem_mod_sel` is one-hot, and bit k is set when register bits 14..13 hold the value k.
- R5: Cycle types on `bus_ctl` are 00 read, 01 read-pause, 10 word write and 11 byte write. Reads give `mem_we`=0 and `mem_be`=11. A word write gives `mem_be`=11. A byte write gives `mem_be`=01 at an even address and 10 at an odd address (address bit 0).
- R6: On a write, `mem_wdata` holds the bus data captured at the claim. Slave sync rises in the cycle after `mem_done` and never earlier.
- R7: On a read or read-pause, `bus_data_out` holds `mem_rdata` sampled with `mem_done`, and `bus_data_oe` rises together with slave sync.
- R8: Slave sync stays high while master sync is high. It and the output enable drop one cycle after master sync goes low.
- R9: After reset, slave sync, `bus_data_oe` and `mem_req` are 0.
- R10: `bus_data_oe` is never high during a write cycle.
- R11: `mem_req` stays high until `mem_done` and is low after it. A master sync still held after the reply starts no new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 5 | Range value compared with address bits 17..13 |
| cfg_mask | input | 5 | Per-bit enable of the range compare |
| cfg_route | input | 1 | Swaps routing of address bits 15 and 1 |
| bus_addr | input | 18 | Bus address |
| bus_ctl | input | 2 | Cycle type |
| bus_msync | input | 1 | Master sync |
| bus_data_in | input | 16 | Data lines as received |
| bus_data_out | output | 16 | Data lines as driven on a read |
| bus_data_oe | output | 1 | Data line driver enable |
| bus_ssync | output | 1 | Slave sync |
| mem_req | output | 1 | Array access request |
| mem_we | output | 1 | Array write |
| mem_be | output | 2 | Array byte lanes |
| mem_addr | output | 15 | Memory address register |
| mem_mod_sel | output | 4 | One-hot array module select |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the array |
| mem_done | input | 1 | Array access complete |

## Verification
A claim is registered on the clock edge that sees master sync with a matching address. From then on, `mem_req`, the address register, the module select, the byte enables and the write data are valid one cycle after sync is driven. Slave sync and the read data appear one cycle after `mem_done`, and both drop one cycle after master sync falls. The bench drives on falling edges and samples on the following falling edge after each of these single-register steps. It also holds `mem_done` low for an extra cycle and holds master sync high past the reply, so that a premature or repeated response shows up.

// File: rtl/sbs_pkg.sv
// Shared types for the system-bus slave front end.
// Assumes a two-bit cycle-type field on the bus.
package sbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_ACK  = 2'd2
    } sbs_state_e;

    localparam logic [1:0] CT_READ   = 2'b00;
    localparam logic [1:0] CT_RPAUSE = 2'b01;
    localparam logic [1:0] CT_WWORD  = 2'b10;
    localparam logic [1:0] CT_WBYTE  = 2'b11;
endpackage

// File: rtl/sbs_match.sv
// Range matcher: compares the high address bits with a configured value.
// Only the bits enabled by the mask take part; it is purely combinational.
module sbs_match #(
    parameter int MATCH_W = 5
) (
    input  logic [MATCH_W-1:0] addr_hi,
    input  logic [MATCH_W-1:0] cfg_base,
    input  logic [MATCH_W-1:0] cfg_mask,
    output logic               hit
);
    // hit when no enabled bit differs
    always_comb begin
        hit = ((addr_hi ^ cfg_base) & cfg_mask) == '0;
    end
endmodule

// File: rtl/sbs_map.sv
// Address mapper: loads the memory address register from an accepted bus
// address and decodes the module select. Assumes an 18-bit bus address
// and a 15-bit register whose top bits name the module.
module sbs_map #(
    parameter int ADDR_W  = 18,
    parameter int MAR_W   = 15,
    parameter int MOD_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cfg_route,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [MAR_W-1:0]  mar,
    output logic [MOD_CNT-1:0] mod_sel
);
    localparam int SEL_W  = $clog2(MOD_CNT);
    localparam int SEL_LO = MAR_W - SEL_W;
    localparam int MID_LO = 1;
    localparam int MID_HI = SEL_LO - 2;

    logic [MAR_W-1:0] mapped;

    // bit placement of the incoming address
    always_comb begin
        mapped = '0;
        mapped[MAR_W-1:SEL_LO]  = bus_addr[MAR_W-1:SEL_LO];
        mapped[MID_HI:MID_LO]   = bus_addr[MID_HI+1:MID_LO+1];
        if (cfg_route) begin
            mapped[SEL_LO-1] = bus_addr[1];
            mapped[0]        = bus_addr[MAR_W];
        end else begin
            mapped[SEL_LO-1] = bus_addr[MAR_W];
            mapped[0]        = bus_addr[1];
        end
    end

    // memory address register
    always_ff @(posedge clk) begin
        if (!rst_n) mar <= '0;
        else if (load) mar <= mapped;
    end

    // one-hot module decode
    for (genvar k = 0; k < MOD_CNT; k++) begin : g_sel
        assign mod_sel[k] = (mar[MAR_W-1:SEL_LO] == SEL_W'(k));
    end

    // R4
    modsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mod_sel) == 1);
endmodule

// File: rtl/sbs_ctrl.sv
// Cycle controller: interlocked sync handshake, array request/done, and
// the write and read data registers. Assumes the master holds address,
// type and data stable while master sync is high.
module sbs_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_msync,
    input  logic              hit,
    input  logic [1:0]        bus_ctl,
    input  logic              byte_odd,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              bus_ssync
);
    import sbs_pkg::*;

    sbs_state_e state;

    // claim decision and array request
    always_comb begin
        load    = (state == ST_IDLE) && bus_msync && hit;
        mem_req = (state == ST_MEM);
    end

    // handshake sequencing and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            mem_we       <= 1'b0;
            mem_be       <= 2'b00;
            mem_wdata    <= '0;
            bus_data_out <= '0;
            bus_data_oe  <= 1'b0;
            bus_ssync    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (load) begin
                    state     <= ST_MEM;
                    mem_we    <= bus_ctl[1];
                    mem_wdata <= bus_data_in;
                    if (bus_ctl == CT_WBYTE) mem_be <= byte_odd ? 2'b10 : 2'b01;
                    else                     mem_be <= 2'b11;
                end
                ST_MEM: if (mem_done) begin
                    state     <= ST_ACK;
                    bus_ssync <= 1'b1;
                    if (!mem_we) begin
                        bus_data_out <= mem_rdata;
                        bus_data_oe  <= 1'b1;
                    end
                end
                ST_ACK: if (!bus_msync) begin
                    state       <= ST_IDLE;
                    bus_ssync   <= 1'b0;
                    bus_data_oe <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(bus_msync && hit));
    // R6
    ssync_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssync) |-> $past(mem_done));
    // R8
    ssync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ssync && bus_msync |=> bus_ssync);
    // R8
    ssync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ssync && !bus_msync |=> !bus_ssync && !bus_data_oe);
    // R10
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !mem_we);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_done |=> mem_req);
endmodule

// File: rtl/sysbus_slave_front.sv
// System-bus slave front end for one memory controller: range claim,
// address mapping, module select and interlocked sync reply.
// Assumes the bus data lines are split into in, out and enable.
module sysbus_slave_front #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int MATCH_W = 5,
    parameter int MAR_W   = 15,
    parameter int MOD_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MATCH_W-1:0] cfg_base,
    input  logic [MATCH_W-1:0] cfg_mask,
    input  logic               cfg_route,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_ctl,
    input  logic               bus_msync,
    input  logic [DATA_W-1:0]  bus_data_in,
    output logic [DATA_W-1:0]  bus_data_out,
    output logic               bus_data_oe,
    output logic               bus_ssync,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_be,
    output logic [MAR_W-1:0]   mem_addr,
    output logic [MOD_CNT-1:0] mem_mod_sel,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_done
);
    logic hit;
    logic load;

    sbs_match #(.MATCH_W(MATCH_W)) u_match (
        .addr_hi  (bus_addr[ADDR_W-1 -: MATCH_W]),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .hit      (hit)
    );

    sbs_map #(.ADDR_W(ADDR_W), .MAR_W(MAR_W), .MOD_CNT(MOD_CNT)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cfg_route (cfg_route),
        .bus_addr  (bus_addr),
        .mar       (mem_addr),
        .mod_sel   (mem_mod_sel)
    );

    sbs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_msync    (bus_msync),
        .hit          (hit),
        .bus_ctl      (bus_ctl),
        .byte_odd     (bus_addr[0]),
        .bus_data_in  (bus_data_in),
        .mem_done     (mem_done),
        .mem_rdata    (mem_rdata),
        .load         (load),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe),
        .bus_ssync    (bus_ssync)
    );
endmodule

// File: tb/tb_sysbus_slave_front.sv
module tb_sysbus_slave_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_base = 5'b10000;
    logic [4:0]  cfg_mask = 5'b11000;
    logic        cfg_route = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [1:0]  bus_ctl = '0;
    logic        bus_msync = 1'b0;
    logic [15:0] bus_data_in = '0;
    logic [15:0] bus_data_out;
    logic        bus_data_oe, bus_ssync, mem_req, mem_we;
    logic [1:0]  mem_be;
    logic [14:0] mem_addr;
    logic [3:0]  mem_mod_sel;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    sysbus_slave_front dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_route(cfg_route), .bus_addr(bus_addr), .bus_ctl(bus_ctl),
        .bus_msync(bus_msync), .bus_data_in(bus_data_in),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_ssync(bus_ssync), .mem_req(mem_req), .mem_we(mem_we),
        .mem_be(mem_be), .mem_addr(mem_addr), .mem_mod_sel(mem_mod_sel),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    // addr, ctl, route, wdata, rdata, expected be, expected module select
    typedef struct packed {
        logic [17:0] addr;
        logic [1:0]  ctl;
        logic        route;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [1:0]  be;
        logic [3:0]  sel;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{18'h2A46C, 2'b10, 1'b0, 16'h1234, 16'h0000, 2'b11, 4'b0010},
        '{18'h27FFE, 2'b00, 1'b1, 16'h0000, 16'hBEEF, 2'b11, 4'b1000},
        '{18'h2C001, 2'b11, 1'b0, 16'hA55A, 16'h0000, 2'b10, 4'b0100},
        '{18'h21110, 2'b11, 1'b0, 16'h00C3, 16'h0000, 2'b01, 4'b0001},
        '{18'h28003, 2'b01, 1'b1, 16'h0000, 16'h5AA5, 2'b11, 4'b0001},
        '{18'h2E00A, 2'b10, 1'b1, 16'hFACE, 16'h0000, 2'b11, 4'b1000}
    };

    // expected address register value from R2 and R3
    function automatic logic [14:0] exp_mar(input logic [17:0] a, input logic r);
        logic [14:0] m;
        m[14:13] = a[14:13];
        m[11:1]  = a[12:2];
        m[12]    = r ? a[1]  : a[15];
        m[0]     = r ? a[15] : a[1];
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cycle(input vec_t v);
        bit wr;
        wr = v.ctl[1];
        @(negedge clk);
        cfg_route = v.route; bus_addr = v.addr; bus_ctl = v.ctl;
        bus_data_in = v.wdata; bus_msync = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b1, "R1 claim", 32'(mem_req), 1);
        chk(mem_addr == exp_mar(v.addr, v.route), "R2 R3 mar", 32'(mem_addr), 32'(exp_mar(v.addr, v.route)));
        chk(mem_mod_sel == v.sel, "R4 modsel", 32'(mem_mod_sel), 32'(v.sel));
        chk(mem_we == wr && mem_be == v.be, "R5 type", {mem_we, mem_be}, {wr, v.be});
        if (wr) chk(mem_wdata == v.wdata, "R6 wdata", 32'(mem_wdata), 32'(v.wdata));
        chk(bus_ssync == 1'b0, "R6 early ssync", 32'(bus_ssync), 0);
        @(negedge clk);
        chk(mem_req == 1'b1 && bus_ssync == 1'b0, "R11 req held", {mem_req, bus_ssync}, 2'b10);
        mem_done = 1'b1; mem_rdata = v.rdata;
        @(negedge clk);
        mem_done = 1'b0; mem_rdata = 16'h0;
        chk(bus_ssync == 1'b1, "R6 R7 ssync", 32'(bus_ssync), 1);
        chk(mem_req == 1'b0, "R11 req drop", 32'(mem_req), 0);
        if (wr) chk(bus_data_oe == 1'b0, "R10 oe on write", 32'(bus_data_oe), 0);
        else chk(bus_data_oe && bus_data_out == v.rdata, "R7 read data",
                 {bus_data_oe, bus_data_out}, {1'b1, v.rdata});
        @(negedge clk);
        @(negedge clk);
        chk(bus_ssync == 1'b1 && mem_req == 1'b0, "R8 R11 hold", {bus_ssync, mem_req}, 2'b10);
        bus_msync = 1'b0; bus_data_in = '0;
        @(negedge clk);
        chk(bus_ssync == 1'b0 && bus_data_oe == 1'b0, "R8 release", {bus_ssync, bus_data_oe}, 0);
    endtask

    task automatic no_claim(input logic [17:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_ctl = 2'b00; bus_msync = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(mem_req == 1'b0 && bus_ssync == 1'b0, req, {mem_req, bus_ssync}, 0);
        bus_msync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(bus_ssync == 0 && bus_data_oe == 0 && mem_req == 0, "R9 reset",
            {bus_ssync, bus_data_oe, mem_req}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) do_cycle(VECS[i]);
        // R1 outside range with partial mask
        no_claim(18'h30000, "R1 mismatch");
        // R1 full mask: match and mismatch on a masked-in low bit
        cfg_base = 5'b10101; cfg_mask = 5'b11111;
        do_cycle('{18'h2A000, 2'b00, 1'b0, 16'h0, 16'h7E81, 2'b11, 4'b0010});
        no_claim(18'h2C000, "R1 full mask mismatch");
        // R9 reset mid-cycle returns to idle outputs
        @(negedge clk);
        bus_addr = 18'h2A000; bus_msync = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_req == 0 && bus_ssync == 0, "R9 reset mid", {mem_req, bus_ssync}, 0);
        bus_msync = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule